// File: doc/BRIEF.md
# I2C Burst Transaction Sequencer

This block carries out one complete I2C transfer, read or write, of up to 17 bytes to a 7-bit target address. It does not drive SCL or SDA itself. It works one level up. It sends byte-level commands (start, stop, write, read, NACK, interrupt acknowledge) together with a transmit byte to a separate byte engine. It then reacts to that engine's byte-complete events, which it checks against the engine's busy and arbitration-lost indications.

On the host side, the flow is as follows:
- Fill the internal byte buffer through a load port.
- Raise a one-cycle request carrying the address, the direction and the length.
- Wait for the completion pulse.

A read leaves the block holding its data, with a data-ready flag raised. The host reads the bytes and the byte count through a read port, then releases the block with an acknowledge strobe. A lost arbitration, or a byte-complete event that arrives with nothing in progress, ends the transfer with a STOP command and an error pulse.

Top module: `i2c_burst_seq`

## Requirements
- R1: After reset the block is idle: `eng_cmd` is 0, `eng_irq_en` is 0, and `data_ready`, `done`, `err`, `req_accept` and `req_reject` are all 0.
- R2: A request is accepted only while idle. A request in any other state, including while read data is waiting, gives a `req_reject` pulse in the next cycle and has no other effect.
- R3: A request is refused with `req_reject` in either of two cases: its length exceeds the buffer depth of 17, or it is a write of length 0. A read of length 0 instead gives `req_accept` and `done` in the next cycle, and no command is ever issued for it.
- R4: `eng_cmd` is nonzero for exactly one cycle per command. Its bit encoding is: bit0 START, bit1 STOP, bit2 WRITE, bit3 READ, bit4 NACK, bit5 IACK. An accepted request is followed by two commands:
  - first, IACK (0x20) with `eng_irq_en` low;
  - in the next cycle, START+WRITE (0x05) with `eng_tx_data` = address<<1 | (1 for read, 0 for write), and `eng_irq_en` high.
- R5: A byte-complete event seen while `eng_busy` is high (and arbitration is not lost) is ignored. No command is issued and the transfer does not advance.
- R6: A byte-complete event with `eng_arb_lost` high aborts the transfer. The next cycle shows STOP (0x02), an `err` pulse and `eng_irq_en` low, and the block is idle again.
- R7: A read requests each byte except the last with READ (0x08), and the last with READ+NACK+STOP (0x1A). Received bytes are stored from the second event onward; the event that answers the address byte stores nothing.
- R8: A write sends buffer bytes 0..len-1 in order. Every byte except the last uses WRITE (0x04); the last uses WRITE+STOP (0x06).
- R9: The event after the final byte command raises `done` for one cycle and drops `eng_irq_en`. After a read, `data_ready` is then set and `rd_count` equals the length. After a write, the block returns to idle.
- R10: A byte-complete event while idle with `eng_busy` low is an error and gives the same abort response as R6.
- R11: While `data_ready` is set, `rd_data` shows buffer entry `rd_idx`. A `rd_ack` clears `data_ready` and returns the block to idle.
- R12: Buffer loads through `load_en` are ignored unless the block is idle. A load made during a write does not change the bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request strobe |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 7 | Target address |
| req_len | input | 5 | Byte count |
| req_accept | output | 1 | Request taken (pulse) |
| req_reject | output | 1 | Request refused (pulse) |
| load_en | input | 1 | Buffer write strobe |
| load_idx | input | 5 | Buffer write index |
| load_data | input | 8 | Buffer write byte |
| rd_idx | input | 5 | Buffer read index |
| rd_data | output | 8 | Buffer byte at `rd_idx` |
| rd_count | output | 5 | Bytes transferred |
| rd_ack | input | 1 | Release read data |
| done | output | 1 | Transfer complete (pulse) |
| data_ready | output | 1 | Read data waiting |
| err | output | 1 | Abort occurred (pulse) |
| eng_cmd | output | 6 | Command bits to byte engine |
| eng_tx_data | output | 8 | Byte to transmit |
| eng_irq_en | output | 1 | Engine interrupt enable |
| eng_irq | input | 1 | Byte-complete event |
| eng_busy | input | 1 | Engine transfer in progress |
| eng_arb_lost | input | 1 | Arbitration lost |
| eng_rx_data | input | 8 | Byte received by engine |

## Verification
The assertions assume the following about the block's inputs:
- A byte-complete event is a one-cycle pulse on `eng_irq`.
- `eng_busy` and `eng_arb_lost` are valid in the same cycle as that pulse.
- `req_valid` is a single-cycle strobe.

The bench stub meets these conditions:
- It raises the event, the busy and arbitration-lost flags and the receive byte together for exactly one clock period. It lowers them at the next falling edge.
- It never issues an event during the two-cycle start sequence.
- Each request lasts one clock period.

// File: rtl/i2c_seq_pkg.sv
// Package: shared state type and command-bit positions for the I2C sequencer.
// Assumes: the byte engine decodes the command bits at the positions below.
package i2c_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ARM  = 3'd1,
        ST_CTRL = 3'd2,
        ST_DATA = 3'd3,
        ST_LAST = 3'd4,
        ST_DRDY = 3'd5
    } seq_state_e;

    localparam int CMD_W   = 6;
    localparam int CB_START = 0;
    localparam int CB_STOP  = 1;
    localparam int CB_WR    = 2;
    localparam int CB_RD    = 3;
    localparam int CB_NACK  = 4;
    localparam int CB_IACK  = 5;
endpackage

// File: rtl/i2c_seq_buf.sv
// Module: byte buffer with a host write port, a capture write port and two
// combinational read ports. Assumes: capture and host writes never coincide
// (capture wins if they do); indices at or above DEPTH are ignored / read 0.
module i2c_seq_buf #(
    parameter int DEPTH = 17,
    parameter int DW    = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [DW-1:0]    host_data,
    input  logic             cap_we,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic [DW-1:0]    cap_data,
    input  logic [IDX_W-1:0] fsm_idx,
    output logic [DW-1:0]    fsm_rdata,
    input  logic [IDX_W-1:0] host_ridx,
    output logic [DW-1:0]    host_rdata
);
    logic [DW-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Storage for one entry: capture port has priority over host port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (cap_we && cap_idx == IDX_W'(g))
                mem[g] <= cap_data;
            else if (host_we && host_idx == IDX_W'(g))
                mem[g] <= host_data;
        end
    end

    // Read ports: out-of-range indices return zero.
    always_comb begin
        fsm_rdata  = '0;
        host_rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (fsm_idx == IDX_W'(i))   fsm_rdata  = mem[i];
            if (host_ridx == IDX_W'(i)) host_rdata = mem[i];
        end
    end
endmodule

// File: rtl/i2c_seq_fsm.sv
// Module: transfer sequencer. Turns a host request into engine byte commands
// and advances on byte-complete events. Assumes: eng_irq is a one-cycle pulse
// with eng_busy/eng_arb_lost valid alongside; req_valid is a one-cycle strobe.
module i2c_seq_fsm
    import i2c_seq_pkg::*;
#(
    parameter int DEPTH = 17,
    parameter int LEN_W = $clog2(DEPTH + 1),
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_read,
    input  logic [6:0]       req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             rd_ack,
    input  logic             eng_irq,
    input  logic             eng_busy,
    input  logic             eng_arb_lost,
    input  logic [7:0]       eng_rx_data,
    input  logic [7:0]       buf_rdata,
    output logic [IDX_W-1:0] buf_idx,
    output logic             cap_we,
    output logic [7:0]       cap_data,
    output logic             is_idle,
    output logic             req_accept,
    output logic             req_reject,
    output logic             done,
    output logic             data_ready,
    output logic             err,
    output logic [LEN_W-1:0] xfer_count,
    output logic [CMD_W-1:0] eng_cmd,
    output logic [7:0]       eng_tx_data,
    output logic             eng_irq_en
);
    localparam logic [CMD_W-1:0] C_IACK  = CMD_W'(1) << CB_IACK;
    localparam logic [CMD_W-1:0] C_STOP  = CMD_W'(1) << CB_STOP;
    localparam logic [CMD_W-1:0] C_WR    = CMD_W'(1) << CB_WR;
    localparam logic [CMD_W-1:0] C_RD    = CMD_W'(1) << CB_RD;
    localparam logic [CMD_W-1:0] C_START = CMD_W'(1) << CB_START;
    localparam logic [CMD_W-1:0] C_NACK  = CMD_W'(1) << CB_NACK;

    seq_state_e       state;
    logic             dir_rd;
    logic [6:0]       addr_q;
    logic [LEN_W-1:0] left_q;
    logic [LEN_W-1:0] ptr_q;
    logic             ev_live, ev_abort, ev_adv, bad_req;

    // Event classification: which states listen, and whether to abort or advance.
    always_comb begin
        ev_live  = eng_irq && (state == ST_IDLE || state == ST_CTRL ||
                               state == ST_DATA || state == ST_LAST);
        ev_abort = ev_live && (eng_arb_lost || (!eng_busy && state == ST_IDLE));
        ev_adv   = ev_live && !eng_arb_lost && !eng_busy && state != ST_IDLE;
        bad_req  = (req_len > LEN_W'(DEPTH)) || (!req_read && req_len == '0);
    end

    // Capture path: received bytes are stored only in DATA and LAST states.
    always_comb begin
        cap_we   = ev_adv && dir_rd && (state == ST_DATA || state == ST_LAST);
        cap_data = eng_rx_data;
        buf_idx  = ptr_q[IDX_W-1:0];
    end

    assign is_idle    = (state == ST_IDLE);
    assign data_ready = (state == ST_DRDY);
    assign xfer_count = ptr_q;

    // Main sequencer: state, counters, registered command outputs and pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            dir_rd      <= 1'b0;
            addr_q      <= '0;
            left_q      <= '0;
            ptr_q       <= '0;
            eng_cmd     <= '0;
            eng_tx_data <= '0;
            eng_irq_en  <= 1'b0;
            req_accept  <= 1'b0;
            req_reject  <= 1'b0;
            done        <= 1'b0;
            err         <= 1'b0;
        end else begin
            eng_cmd    <= '0;
            req_accept <= 1'b0;
            req_reject <= 1'b0;
            done       <= 1'b0;
            err        <= 1'b0;
            if (ev_abort) begin
                state      <= ST_IDLE;
                eng_irq_en <= 1'b0;
                eng_cmd    <= C_STOP;
                err        <= 1'b1;
            end
            case (state)
                ST_IDLE: begin
                    if (req_valid && (ev_abort || bad_req)) begin
                        req_reject <= 1'b1;
                    end else if (req_valid && req_len == '0) begin
                        req_accept <= 1'b1;
                        done       <= 1'b1;
                    end else if (req_valid) begin
                        req_accept <= 1'b1;
                        dir_rd     <= req_read;
                        addr_q     <= req_addr;
                        left_q     <= req_len;
                        ptr_q      <= '0;
                        state      <= ST_ARM;
                        eng_irq_en <= 1'b0;
                        eng_cmd    <= C_IACK;
                    end
                end
                ST_ARM: begin
                    eng_cmd     <= C_START | C_WR;
                    eng_tx_data <= {addr_q, dir_rd};
                    eng_irq_en  <= 1'b1;
                    state       <= ST_CTRL;
                end
                ST_CTRL, ST_DATA: begin
                    if (ev_adv) begin
                        if (dir_rd) begin
                            if (state == ST_DATA) ptr_q <= ptr_q + LEN_W'(1);
                            eng_cmd <= (left_q > LEN_W'(1)) ? C_RD
                                                            : (C_RD | C_NACK | C_STOP);
                        end else begin
                            eng_tx_data <= buf_rdata;
                            ptr_q       <= ptr_q + LEN_W'(1);
                            eng_cmd     <= (left_q > LEN_W'(1)) ? C_WR : (C_WR | C_STOP);
                        end
                        left_q <= left_q - LEN_W'(1);
                        state  <= (left_q == LEN_W'(1)) ? ST_LAST : ST_DATA;
                    end
                end
                ST_LAST: begin
                    if (ev_adv) begin
                        if (dir_rd) begin
                            ptr_q <= ptr_q + LEN_W'(1);
                            state <= ST_DRDY;
                        end else begin
                            state <= ST_IDLE;
                        end
                        eng_irq_en <= 1'b0;
                        done       <= 1'b1;
                    end
                end
                ST_DRDY: begin
                    if (rd_ack) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
            if (req_valid && state != ST_IDLE) req_reject <= 1'b1;
        end
    end

    // R4: IACK is always followed by START+WRITE with interrupts enabled.
    a_r4_addr_after_iack: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cmd[CB_IACK] |=> (eng_cmd == (C_START | C_WR)) && eng_irq_en);

    // R6: arbitration loss on a live event yields STOP, error and interrupts off.
    a_r6_arb_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_live && eng_arb_lost) |=> (eng_cmd == C_STOP) && err && !eng_irq_en);

    // R5: a busy event neither issues a command nor moves the state.
    a_r5_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_irq && eng_busy && !eng_arb_lost && state != ST_IDLE && state != ST_ARM)
        |=> (eng_cmd == '0) && (state == $past(state)));

    // R2: a request outside IDLE is refused.
    a_r2_reject_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && state != ST_IDLE) |=> req_reject && !req_accept);

    // R7: NACK only ever travels with READ and STOP.
    a_r7_nack_last: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cmd[CB_NACK] |-> eng_cmd[CB_RD] && eng_cmd[CB_STOP]);

    // R9: completion leaves the engine interrupt disabled.
    a_r9_done_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !eng_irq_en);

    // R11: acknowledge releases waiting read data.
    a_r11_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && rd_ack) |=> !data_ready);
endmodule

// File: rtl/i2c_burst_seq.sv
// Module: top of the I2C burst sequencer. Joins the byte buffer and the
// sequencer FSM; host buffer loads are only let through while idle.
// Assumes: a byte engine that acts on eng_cmd and reports byte completion.
module i2c_burst_seq
    import i2c_seq_pkg::*;
#(
    parameter int DEPTH = 17,
    parameter int LEN_W = $clog2(DEPTH + 1),
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_read,
    input  logic [6:0]       req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_accept,
    output logic             req_reject,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [7:0]       load_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic [LEN_W-1:0] rd_count,
    input  logic             rd_ack,
    output logic             done,
    output logic             data_ready,
    output logic             err,
    output logic [CMD_W-1:0] eng_cmd,
    output logic [7:0]       eng_tx_data,
    output logic             eng_irq_en,
    input  logic             eng_irq,
    input  logic             eng_busy,
    input  logic             eng_arb_lost,
    input  logic [7:0]       eng_rx_data
);
    logic [IDX_W-1:0] buf_idx;
    logic [7:0]       buf_rdata, cap_data;
    logic             cap_we, is_idle;

    i2c_seq_buf #(.DEPTH(DEPTH), .DW(8), .IDX_W(IDX_W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (load_en && is_idle),
        .host_idx   (load_idx),
        .host_data  (load_data),
        .cap_we     (cap_we),
        .cap_idx    (buf_idx),
        .cap_data   (cap_data),
        .fsm_idx    (buf_idx),
        .fsm_rdata  (buf_rdata),
        .host_ridx  (rd_idx),
        .host_rdata (rd_data)
    );

    i2c_seq_fsm #(.DEPTH(DEPTH), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_read     (req_read),
        .req_addr     (req_addr),
        .req_len      (req_len),
        .rd_ack       (rd_ack),
        .eng_irq      (eng_irq),
        .eng_busy     (eng_busy),
        .eng_arb_lost (eng_arb_lost),
        .eng_rx_data  (eng_rx_data),
        .buf_rdata    (buf_rdata),
        .buf_idx      (buf_idx),
        .cap_we       (cap_we),
        .cap_data     (cap_data),
        .is_idle      (is_idle),
        .req_accept   (req_accept),
        .req_reject   (req_reject),
        .done         (done),
        .data_ready   (data_ready),
        .err          (err),
        .xfer_count   (rd_count),
        .eng_cmd      (eng_cmd),
        .eng_tx_data  (eng_tx_data),
        .eng_irq_en   (eng_irq_en)
    );
endmodule

// File: tb/i2c_burst_seq_tb_top.sv
// Bench: directed scenarios, each task drives one case and checks its results.
// The byte engine is a stub: tasks raise one-cycle events with busy/arb/rx data.
module i2c_burst_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 0, req_read = 0;
    logic [6:0] req_addr = 0;
    logic [4:0] req_len = 0;
    logic       req_accept, req_reject;
    logic       load_en = 0;
    logic [4:0] load_idx = 0;
    logic [7:0] load_data = 0;
    logic [4:0] rd_idx = 0;
    logic [7:0] rd_data;
    logic [4:0] rd_count;
    logic       rd_ack = 0;
    logic       done, data_ready, err;
    logic [5:0] eng_cmd;
    logic [7:0] eng_tx_data;
    logic       eng_irq_en;
    logic       eng_irq = 0, eng_busy = 0, eng_arb_lost = 0;
    logic [7:0] eng_rx_data = 0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    i2c_burst_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_read(req_read), .req_addr(req_addr), .req_len(req_len),
        .req_accept(req_accept), .req_reject(req_reject),
        .load_en(load_en), .load_idx(load_idx), .load_data(load_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_count(rd_count), .rd_ack(rd_ack),
        .done(done), .data_ready(data_ready), .err(err),
        .eng_cmd(eng_cmd), .eng_tx_data(eng_tx_data), .eng_irq_en(eng_irq_en),
        .eng_irq(eng_irq), .eng_busy(eng_busy), .eng_arb_lost(eng_arb_lost),
        .eng_rx_data(eng_rx_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [7:0] d);
        load_en = 1; load_idx = 5'(idx); load_data = d;
        @(negedge clk);
        load_en = 0;
    endtask

    // Issue a request; results of the request cycle are visible on return.
    task automatic request(input logic rd, input logic [6:0] a, input int len);
        req_valid = 1; req_read = rd; req_addr = a; req_len = 5'(len);
        @(negedge clk);
        req_valid = 0;
    endtask

    // Request plus start sequence checks (R4).
    task automatic start_xfer(input logic rd, input logic [6:0] a, input int len);
        request(rd, a, len);
        chk("R4 accept", {31'b0, req_accept}, 1);
        chk("R4 iack cmd", {26'b0, eng_cmd}, 32'h20);
        chk("R4 irq_en low during iack", {31'b0, eng_irq_en}, 0);
        @(negedge clk);
        chk("R4 start+write cmd", {26'b0, eng_cmd}, 32'h05);
        chk("R4 address byte", {24'b0, eng_tx_data}, {24'b0, a, rd});
        chk("R4 irq_en high", {31'b0, eng_irq_en}, 1);
    endtask

    // One engine byte-complete event; outputs of the response on return.
    task automatic ev(input logic busy, input logic arb, input logic [7:0] rx);
        eng_irq = 1; eng_busy = busy; eng_arb_lost = arb; eng_rx_data = rx;
        @(negedge clk);
        eng_irq = 0; eng_busy = 0; eng_arb_lost = 0;
    endtask

    task automatic t_reset();
        chk("R1 cmd", {26'b0, eng_cmd}, 0);
        chk("R1 irq_en", {31'b0, eng_irq_en}, 0);
        chk("R1 flags", {27'b0, data_ready, done, err, req_accept, req_reject}, 0);
    endtask

    task automatic t_write3();
        load(0, 8'hA1); load(1, 8'hB2); load(2, 8'hC3);
        start_xfer(0, 7'h50, 3);
        ev(1, 0, 8'h00);
        chk("R5 busy event no cmd", {26'b0, eng_cmd}, 0);
        ev(0, 0, 8'h00);
        chk("R8 byte0 WR", {26'b0, eng_cmd}, 32'h04);
        chk("R8 byte0 data", {24'b0, eng_tx_data}, 32'hA1);
        load(2, 8'hEE);
        ev(1, 0, 8'h00);
        chk("R5 busy event mid write", {26'b0, eng_cmd}, 0);
        ev(0, 0, 8'h00);
        chk("R8 byte1 WR", {26'b0, eng_cmd}, 32'h04);
        chk("R8 byte1 data", {24'b0, eng_tx_data}, 32'hB2);
        ev(0, 0, 8'h00);
        chk("R8 last WR+STOP", {26'b0, eng_cmd}, 32'h06);
        chk("R12 load ignored while busy", {24'b0, eng_tx_data}, 32'hC3);
        ev(0, 0, 8'h00);
        chk("R9 write done", {31'b0, done}, 1);
        chk("R9 irq_en off", {31'b0, eng_irq_en}, 0);
        chk("R9 no data_ready for write", {31'b0, data_ready}, 0);
        chk("R9 no cmd at done", {26'b0, eng_cmd}, 0);
    endtask

    task automatic t_read3();
        start_xfer(1, 7'h3C, 3);
        ev(0, 0, 8'h99);
        chk("R7 first RD", {26'b0, eng_cmd}, 32'h08);
        ev(0, 0, 8'h11);
        chk("R7 second RD", {26'b0, eng_cmd}, 32'h08);
        ev(0, 0, 8'h22);
        chk("R7 last RD+NACK+STOP", {26'b0, eng_cmd}, 32'h1A);
        ev(0, 0, 8'h33);
        chk("R9 read done", {31'b0, done}, 1);
        chk("R9 data_ready", {31'b0, data_ready}, 1);
        chk("R9 count", {27'b0, rd_count}, 3);
        rd_idx = 0; #1 chk("R7 byte0 (no capture after address)", {24'b0, rd_data}, 32'h11);
        rd_idx = 1; #1 chk("R11 byte1", {24'b0, rd_data}, 32'h22);
        rd_idx = 2; #1 chk("R11 byte2", {24'b0, rd_data}, 32'h33);
        request(0, 7'h10, 1);
        chk("R2 reject while data waiting", {31'b0, req_reject}, 1);
        chk("R2 no accept", {31'b0, req_accept}, 0);
        chk("R2 data still ready", {31'b0, data_ready}, 1);
        rd_ack = 1; @(negedge clk); rd_ack = 0;
        chk("R11 released", {31'b0, data_ready}, 0);
    endtask

    task automatic t_arb();
        start_xfer(1, 7'h22, 4);
        ev(0, 0, 8'h00);
        request(0, 7'h11, 2);
        chk("R2 reject mid transfer", {31'b0, req_reject}, 1);
        ev(1, 1, 8'h00);
        chk("R6 STOP cmd", {26'b0, eng_cmd}, 32'h02);
        chk("R6 err pulse", {31'b0, err}, 1);
        chk("R6 irq_en off", {31'b0, eng_irq_en}, 0);
        request(1, 7'h22, 0);
        chk("R6 idle after abort", {31'b0, req_accept}, 1);
    endtask

    task automatic t_lengths();
        request(1, 7'h01, 18);
        chk("R3 too long rejected", {31'b0, req_reject}, 1);
        request(0, 7'h01, 0);
        chk("R3 zero write rejected", {31'b0, req_reject}, 1);
        request(1, 7'h01, 0);
        chk("R3 zero read accepted", {31'b0, req_accept}, 1);
        chk("R3 zero read done", {31'b0, done}, 1);
        chk("R3 zero read no cmd", {26'b0, eng_cmd}, 0);
        @(negedge clk);
        chk("R3 zero read still no cmd", {26'b0, eng_cmd}, 0);
    endtask

    task automatic t_idle_event();
        ev(1, 0, 8'h00);
        chk("R10 busy idle event ignored", {26'b0, eng_cmd, err}, 0);
        ev(0, 0, 8'h00);
        chk("R10 idle event STOP", {26'b0, eng_cmd}, 32'h02);
        chk("R10 idle event err", {31'b0, err}, 1);
    endtask

    task automatic t_read1();
        start_xfer(1, 7'h7F, 1);
        ev(0, 0, 8'h00);
        chk("R7 single read RD+NACK+STOP", {26'b0, eng_cmd}, 32'h1A);
        ev(0, 0, 8'h5A);
        chk("R9 single count", {27'b0, rd_count}, 1);
        rd_idx = 0; #1 chk("R7 single byte", {24'b0, rd_data}, 32'h5A);
        rd_ack = 1; @(negedge clk); rd_ack = 0;
    endtask

    task automatic t_write17();
        for (int i = 0; i < 17; i++) load(i, 8'(i * 3 + 1));
        start_xfer(0, 7'h2A, 17);
        for (int i = 0; i < 17; i++) begin
            ev(0, 0, 8'h00);
            chk("R8 long cmd", {26'b0, eng_cmd}, (i == 16) ? 32'h06 : 32'h04);
            chk("R8 long data", {24'b0, eng_tx_data}, 32'(i * 3 + 1));
        end
        ev(0, 0, 8'h00);
        chk("R9 long write done", {31'b0, done}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write3();
        t_read3();
        t_arb();
        t_lengths();
        t_idle_event();
        t_read1();
        t_write17();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule